// File: doc/BRIEF.md
# Power Domain Idle Controller

This block decides which units of a processor clock domain are idled. The units are the CPU core, an FFT accelerator and four bus ports: data, I/O, memory and instruction. Software first writes a configuration word that holds one idle request bit per unit and a fixed four-bit guard pattern. It then pulses an idle command. On that pulse the block checks the word against the dependency rules of the domain.

A legal word replaces the set of idled units, and the result shows in a 16-bit read-only status word and on one idle-enable line per unit. An illegal word raises a sticky bus-error flag and leaves every unit as it was. If the memory port is asked to idle while DMA traffic into on-chip RAM is still in flight, the whole requested set waits and then enters idle together once that traffic stops. A wake event brings every unit back to active and drops any idle entry that is still waiting.

All pins are plain control and status signals. No pin carries a data stream, so there is no valid/ready handshake and nothing can stall.

Top module: `pwr_idle_ctrl`

## Requirements
- R1: After reset, `idle_status`, `unit_idle` and `bus_err` are all 0.
- R2: Status bit positions are fixed: bit 0 is the CPU, bit 5 the data port, bit 6 the I/O port, bit 7 the memory port, bit 8 the instruction port and bit 9 the accelerator. Bits 15:10 and 4:1 always read 0, and a 1 means the unit is idled. `unit_idle` bits 0 to 5 carry the CPU, data, I/O, memory, instruction and accelerator states, each equal to its status bit. Idle request bits in the configuration word use the same positions as the status bits.
- R3: A write with `cfg_wr_addr`=0 loads the configuration word at the next edge. An idle command in the same cycle as that write is judged on the value held before the write.
- R4: A legal idle command that needs no wait replaces the status with the requested set on the next cycle. Units that are not requested become active.
- R5: A command is illegal if any of the data, I/O, memory or instruction port requests is set while configuration bits 4:1 are not 0111 (bits 1, 2 and 3 set, bit 4 clear).
- R6: A command is illegal if the data, I/O or instruction port request is set while the CPU request (bit 0) is clear.
- R7: An illegal command sets `bus_err` on the next cycle. It changes neither the status nor an idle entry that is already waiting.
- R8: When a legal command requests the memory port while `dma_busy` is high, nothing changes yet. The whole requested set enters idle on the cycle after the first cycle in which `dma_busy` is sampled low.
- R9: CPU and accelerator requests have no precondition. Without a memory-port request they apply at once, whatever the state of `dma_busy` and the guard pattern.
- R10: `bus_err` stays set until a write with `cfg_wr_addr`=1 and data bit 0 equal to 1. That write clears the flag on the next cycle. An illegal command in the same cycle wins over the clear, and a clear write with data bit 0 equal to 0 has no effect.
- R11: A `wake` pulse clears all status bits on the next cycle and cancels a waiting idle entry. A legal command in the wake cycle is dropped, but an illegal one still sets `bus_err`.
- R12: A legal command issued while an earlier entry is still waiting replaces that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 1 | 0 selects the configuration word, 1 selects the error-clear register |
| cfg_wr_data | input | 16 | Write data |
| idle_cmd | input | 1 | One-cycle idle command pulse |
| dma_busy | input | 1 | High while any DMA master is accessing on-chip RAM |
| wake | input | 1 | Wake event pulse |
| unit_idle | output | 6 | Per-unit idle enables: CPU, data, I/O, memory, instruction, accelerator |
| idle_status | output | 16 | Read-only idle status word |
| bus_err | output | 1 | Sticky illegal-command flag |

## Verification
A wrong legality decision shows one cycle after the command: either `bus_err` rises when it should not, or the status word moves when it should not. A corrupted waiting entry stays hidden until `dma_busy` falls, and then the wrong set appears on the next cycle. For that reason, the bench holds `dma_busy` high for several cycles, sends illegal and replacing commands while an entry waits, and then releases it. A wake that is missed or ignored leaves nonzero status bits on the cycle after the pulse, so every output is compared with the reference model on every clock.

// File: rtl/pwr_idle_pkg.sv
package pwr_idle_pkg;

  localparam int unsigned WORD_W    = 16;
  localparam int unsigned NUM_UNITS = 6;

  // Index of each unit inside the per-unit vectors.
  localparam int unsigned U_CPU   = 0;
  localparam int unsigned U_DATA  = 1;
  localparam int unsigned U_IO    = 2;
  localparam int unsigned U_MEM   = 3;
  localparam int unsigned U_INSTR = 4;
  localparam int unsigned U_ACCEL = 5;

  // Guard field in the configuration word.
  localparam int unsigned GUARD_LO = 1;
  localparam int unsigned GUARD_W  = 4;
  localparam logic [GUARD_W-1:0] GUARD_VAL = 4'b0111;

  // Status/config bit position of each unit.
  function automatic int unsigned unit_bit(input int unsigned k);
    case (k)
      U_CPU:   return 0;
      U_DATA:  return 5;
      U_IO:    return 6;
      U_MEM:   return 7;
      U_INSTR: return 8;
      default: return 9;
    endcase
  endfunction

  typedef enum logic [0:0] {
    SEQ_RUN  = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;

endpackage

// File: rtl/idle_cfg_reg.sv
module idle_cfg_reg
  import pwr_idle_pkg::*;
#(
  parameter int unsigned DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] cfg_q,
  output logic          err_clr
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (wr_en && !wr_addr) begin
      cfg_q <= wr_data;
    end
  end

  // Error clear is a write-one-to-clear strobe, passed on combinationally.
  assign err_clr = wr_en && wr_addr && wr_data[0];

endmodule

// File: rtl/idle_rule_check.sv
module idle_rule_check
  import pwr_idle_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned NU = NUM_UNITS
) (
  input  logic [DW-1:0] cfg,
  output logic [NU-1:0] req_vec,
  output logic          legal
);

  logic               port_any;
  logic               cpu_dep_any;
  logic               guard_ok;
  logic [GUARD_W-1:0] guard;

  for (genvar k = 0; k < NU; k++) begin : g_req
    assign req_vec[k] = cfg[unit_bit(k)];
  end

  assign guard       = cfg[GUARD_LO +: GUARD_W];
  assign guard_ok    = (guard == GUARD_VAL);
  assign port_any    = req_vec[U_DATA] | req_vec[U_IO] | req_vec[U_MEM] | req_vec[U_INSTR];
  assign cpu_dep_any = req_vec[U_DATA] | req_vec[U_IO] | req_vec[U_INSTR];

  always_comb begin
    legal = 1'b1;
    if (port_any && !guard_ok)        legal = 1'b0;
    if (cpu_dep_any && !req_vec[U_CPU]) legal = 1'b0;
  end

  logic unused_cfg;
  assign unused_cfg = ^{cfg[DW-1:10], cfg[4]};

endmodule

// File: rtl/idle_sequencer.sv
module idle_sequencer
  import pwr_idle_pkg::*;
#(
  parameter int unsigned NU = NUM_UNITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd,
  input  logic          legal,
  input  logic [NU-1:0] req_vec,
  input  logic          dma_busy,
  input  logic          wake,
  input  logic          err_clr,
  output logic [NU-1:0] stat_vec,
  output logic          bus_err,
  output logic          waiting
);

  seq_state_e    state_q;
  logic [NU-1:0] stat_q;
  logic [NU-1:0] pend_q;
  logic          err_q;
  logic          take;
  logic          must_wait;

  assign take      = cmd && legal;
  assign must_wait = req_vec[U_MEM] && dma_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (cmd && !legal) begin
      err_q <= 1'b1;
    end else if (err_clr) begin
      err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_RUN;
      stat_q  <= '0;
      pend_q  <= '0;
    end else if (wake) begin
      state_q <= SEQ_RUN;
      stat_q  <= '0;
    end else if (take) begin
      if (must_wait) begin
        state_q <= SEQ_WAIT;
        pend_q  <= req_vec;
      end else begin
        state_q <= SEQ_RUN;
        stat_q  <= req_vec;
      end
    end else if (state_q == SEQ_WAIT && !dma_busy) begin
      state_q <= SEQ_RUN;
      stat_q  <= pend_q;
    end
  end

  assign stat_vec = stat_q;
  assign bus_err  = err_q;
  assign waiting  = (state_q == SEQ_WAIT);

endmodule

// File: rtl/pwr_idle_ctrl.sv
module pwr_idle_ctrl
  import pwr_idle_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned NU = NUM_UNITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic          cfg_wr_addr,
  input  logic [DW-1:0] cfg_wr_data,
  input  logic          idle_cmd,
  input  logic          dma_busy,
  input  logic          wake,
  output logic [NU-1:0] unit_idle,
  output logic [DW-1:0] idle_status,
  output logic          bus_err
);

  logic [DW-1:0] cfg_q;
  logic          err_clr;
  logic [NU-1:0] req_vec;
  logic          rule_legal;
  logic          cmd_illegal;
  logic [NU-1:0] stat_vec;
  logic          seq_waiting;

  idle_cfg_reg #(.DW(DW)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_wr_addr),
    .wr_data (cfg_wr_data),
    .cfg_q   (cfg_q),
    .err_clr (err_clr)
  );

  idle_rule_check #(.DW(DW), .NU(NU)) u_rule (
    .cfg     (cfg_q),
    .req_vec (req_vec),
    .legal   (rule_legal)
  );

  assign cmd_illegal = !rule_legal;

  idle_sequencer #(.NU(NU)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (idle_cmd),
    .legal    (rule_legal),
    .req_vec  (req_vec),
    .dma_busy (dma_busy),
    .wake     (wake),
    .err_clr  (err_clr),
    .stat_vec (stat_vec),
    .bus_err  (bus_err),
    .waiting  (seq_waiting)
  );

  always_comb begin
    idle_status = '0;
    for (int unsigned k = 0; k < NU; k++) begin
      idle_status[unit_bit(k)] = stat_vec[k];
    end
  end

  assign unit_idle = stat_vec;

endmodule

// File: rtl/idle_ctrl_chk.sv
module idle_ctrl_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned NU = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          idle_cmd,
  input logic          cmd_illegal,
  input logic          seq_waiting,
  input logic          wake,
  input logic          dma_busy,
  input logic          cfg_wr_en,
  input logic          cfg_wr_addr,
  input logic [DW-1:0] cfg_wr_data,
  input logic [NU-1:0] unit_idle,
  input logic [DW-1:0] idle_status,
  input logic          bus_err
);

  localparam logic [15:0] RSVD_MASK = 16'hFC1E;

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_status[15:0] & RSVD_MASK) == 16'h0000);

  assert_cpu_dep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_idle[1] | unit_idle[2] | unit_idle[4]) |-> unit_idle[0]);

  assert_illegal_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cmd && cmd_illegal && !wake && !seq_waiting) |=> (bus_err && $stable(idle_status)));

  assert_mem_dma_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unit_idle[3]) |-> !$past(dma_busy));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !(cfg_wr_en && cfg_wr_addr && cfg_wr_data[0])) |=> bus_err);

  assert_wake_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (idle_status == '0));

endmodule

bind pwr_idle_ctrl idle_ctrl_chk #(.DW(DW), .NU(NU)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .idle_cmd    (idle_cmd),
  .cmd_illegal (cmd_illegal),
  .seq_waiting (seq_waiting),
  .wake        (wake),
  .dma_busy    (dma_busy),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_addr (cfg_wr_addr),
  .cfg_wr_data (cfg_wr_data),
  .unit_idle   (unit_idle),
  .idle_status (idle_status),
  .bus_err     (bus_err)
);

// File: tb/test_pwr_idle_ctrl.sv
`timescale 1ns/1ps
module test_pwr_idle_ctrl;

  localparam logic [15:0] CPU = 16'h0001;
  localparam logic [15:0] DP  = 16'h0020;
  localparam logic [15:0] XP  = 16'h0040;
  localparam logic [15:0] MP  = 16'h0080;
  localparam logic [15:0] IP  = 16'h0100;
  localparam logic [15:0] HA  = 16'h0200;
  localparam logic [15:0] PAT = 16'h000E;
  localparam logic [15:0] REQ_MASK = 16'h03E1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_wr_addr = 1'b0;
  logic [15:0] cfg_wr_data = '0;
  logic        idle_cmd = 1'b0;
  logic        dma_busy = 1'b0;
  logic        wake = 1'b0;
  logic [5:0]  unit_idle;
  logic [15:0] idle_status;
  logic        bus_err;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_idle_ctrl i_pwr_idle_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .idle_cmd(idle_cmd), .dma_busy(dma_busy), .wake(wake),
    .unit_idle(unit_idle), .idle_status(idle_status), .bus_err(bus_err)
  );

  // Behavioural reference model
  logic [15:0] m_cfg, m_stat, m_pend;
  bit          m_wait, m_err;

  function automatic logic [5:0] to_units(input logic [15:0] s);
    return {s[9], s[8], s[7], s[6], s[5], s[0]};
  endfunction

  function automatic bit is_illegal(input logic [15:0] c);
    bit ports, dep;
    ports = (c & (DP | XP | MP | IP)) != 0;
    dep   = (c & (DP | XP | IP)) != 0;
    return (ports && c[4:1] != 4'b0111) || (dep && !c[0]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = '0; m_stat = '0; m_pend = '0; m_wait = 0; m_err = 0;
    end else begin
      bit ill;
      logic [15:0] req;
      ill = is_illegal(m_cfg);
      req = m_cfg & REQ_MASK;
      if (idle_cmd && ill) m_err = 1;
      else if (cfg_wr_en && cfg_wr_addr && cfg_wr_data[0]) m_err = 0;
      if (wake) begin
        m_stat = '0; m_wait = 0;
      end else if (idle_cmd && !ill) begin
        if (req[7] && dma_busy) begin m_wait = 1; m_pend = req; end
        else begin m_stat = req; m_wait = 0; end
      end else if (m_wait && !dma_busy) begin
        m_stat = m_pend; m_wait = 0;
      end
      if (cfg_wr_en && !cfg_wr_addr) m_cfg = cfg_wr_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_cmp++;
      if (idle_status !== m_stat || unit_idle !== to_units(m_stat) || bus_err !== m_err) begin
        n_bad++;
        $display("FAIL %s model: status=%h units=%b err=%b expected status=%h units=%b err=%b",
                 cur_req, idle_status, unit_idle, bus_err, m_stat, to_units(m_stat), m_err);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    cfg_wr_en = 0; idle_cmd = 0; wake = 0;
  endtask

  task automatic wr_cfg(input logic [15:0] d);
    cfg_wr_en = 1; cfg_wr_addr = 0; cfg_wr_data = d; step();
  endtask

  task automatic clr_err(input logic [15:0] d);
    cfg_wr_en = 1; cfg_wr_addr = 1; cfg_wr_data = d; step();
  endtask

  task automatic cmd();
    idle_cmd = 1; step();
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    #1;
    cur_req = "R1";
    chk("R1 status", idle_status, 16'h0);
    chk("R1 units", {10'b0, unit_idle}, 16'h0);
    chk("R1 err", {15'b0, bus_err}, 16'h0);

    // R9: CPU + accelerator with no guard, DMA busy
    cur_req = "R9";
    dma_busy = 1;
    wr_cfg(CPU | HA);
    cmd();
    chk("R9 cpu+accel", idle_status, CPU | HA);
    chk("R2 units", {10'b0, unit_idle}, 16'h0021);

    // R3: same-cycle write and command uses old value
    cur_req = "R3";
    wr_cfg(HA);
    cfg_wr_en = 1; cfg_wr_addr = 0; cfg_wr_data = CPU; idle_cmd = 1; step();
    chk("R3 old cfg used", idle_status, HA);
    cmd();
    chk("R3 new cfg", idle_status, CPU);
    dma_busy = 0;

    // R5 / R7: port request without guard
    cur_req = "R5";
    wr_cfg(CPU | DP);
    cmd();
    chk("R5 err", {15'b0, bus_err}, 16'h1);
    chk("R7 status held", idle_status, CPU);

    // R10: sticky, write-zero no effect, write-one clears
    cur_req = "R10";
    clr_err(16'h0000);
    chk("R10 write0 keeps", {15'b0, bus_err}, 16'h1);
    step();
    chk("R10 sticky", {15'b0, bus_err}, 16'h1);
    clr_err(16'h0001);
    chk("R10 cleared", {15'b0, bus_err}, 16'h0);

    // R6: port without CPU
    cur_req = "R6";
    wr_cfg(DP | PAT);
    cmd();
    chk("R6 err", {15'b0, bus_err}, 16'h1);
    chk("R6 status held", idle_status, CPU);
    clr_err(16'h0001);

    // R4: legal multi-port entry, replacing
    cur_req = "R4";
    wr_cfg(CPU | DP | XP | IP | PAT);
    cmd();
    chk("R4 applied", idle_status, CPU | DP | XP | IP);
    chk("R2 units", {10'b0, unit_idle}, 16'h0017);

    // R8: memory port waits for DMA
    cur_req = "R8";
    dma_busy = 1;
    wr_cfg(CPU | MP | HA | PAT);
    cmd();
    chk("R8 waiting", idle_status, CPU | DP | XP | IP);
    repeat (3) step();
    chk("R8 still waiting", idle_status, CPU | DP | XP | IP);
    dma_busy = 0;
    step();
    chk("R8 entered", idle_status, CPU | MP | HA);

    // R12: replacement while waiting
    cur_req = "R12";
    dma_busy = 1;
    wr_cfg(MP | PAT);
    cmd();
    wr_cfg(MP | CPU | PAT);
    cmd();
    dma_busy = 0;
    step();
    chk("R12 replaced", idle_status, MP | CPU);

    // R7: illegal command while waiting leaves entry
    cur_req = "R7";
    wake = 1; step();
    dma_busy = 1;
    wr_cfg(MP | HA | PAT);
    cmd();
    wr_cfg(IP);
    cmd();
    chk("R7 err", {15'b0, bus_err}, 16'h1);
    chk("R7 no change", idle_status, 16'h0);
    dma_busy = 0;
    step();
    chk("R7 entry kept", idle_status, MP | HA);
    clr_err(16'h0001);

    // R11: wake cancels waiting entry
    cur_req = "R11";
    dma_busy = 1;
    wr_cfg(CPU | MP | PAT);
    cmd();
    wake = 1; step();
    chk("R11 cleared", idle_status, 16'h0);
    dma_busy = 0;
    repeat (2) step();
    chk("R11 cancelled", idle_status, 16'h0);
    wr_cfg(CPU | HA);
    wake = 1; idle_cmd = 1; step();
    chk("R11 cmd dropped", idle_status, 16'h0);
    wr_cfg(XP | PAT);
    wake = 1; idle_cmd = 1; step();
    chk("R11 illegal flagged", {15'b0, bus_err}, 16'h1);

    // R10: set wins over clear
    cur_req = "R10";
    clr_err(16'h0001);
    cfg_wr_en = 1; cfg_wr_addr = 1; cfg_wr_data = 16'h0001; idle_cmd = 1; step();
    chk("R10 set wins", {15'b0, bus_err}, 16'h1);
    clr_err(16'h0001);

    // R2: reserved bits stay zero even with all config bits set
    cur_req = "R2";
    wr_cfg(16'hFFF1 & ~16'h0010 | PAT);
    cmd();
    chk("R2 reserved zero", idle_status & 16'hFC1E, 16'h0);
    chk("R2 all units", idle_status, REQ_MASK);

    // Random traffic against the model
    cur_req = "R4";
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      cfg_wr_en   = r[0];
      cfg_wr_addr = (r[3:1] == 0);
      cfg_wr_data = r[4] ? ((r[31:16] & REQ_MASK) | PAT) : r[31:16];
      idle_cmd    = r[5];
      dma_busy    = r[7:6] != 0;
      wake        = (r[12:8] == 0);
      @(posedge clk); #2;
    end
    cfg_wr_en = 0; idle_cmd = 0; wake = 0;
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end

endmodule